// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel coordinate into the byte offset of that pixel inside a surface stored in macro-tiled form. The surface is split into 8x8-element micro tiles. Micro tiles are grouped into macro tiles, and the address is spread over several memory channels and banks. The block XORs low and middle coordinate bits to pick a channel and a bank. It orders the pixels inside each micro tile according to element size and surface kind. It then splices the channel and bank fields into the linear offset just above the interleave group boundary.

A requester presents a coordinate, the surface pitch, the element size, the depth and stencil flags and a configuration set. The configuration set gives the group size, the channel count, the bank count and the alternate bank swizzle. The requester raises `valid_in`. Three register stages later the offset appears with `valid_out`. The stages are: swizzle and tile indices, then the macro tile product, then the final splice. Only one sample and the first slice are covered. A `stall` input freezes every stage.

Top module: `tiled_addr_gen`

## Requirements
- R1: Channel select, written as `ch_cfg` one-hot with bit0 = 2 channels, bit1 = 4 channels and bit2 = 8 channels.
  - 2 channels: ch0 = x3^y3.
  - 4 channels: ch0 = x4^y3 and ch1 = x3^y4.
  - 8 channels: ch0 = x5^y3, ch1 = x4^x5^y4 and ch2 = x3^y5.
  - Channel bits c = log2(channels).
- R2: Bank select, written as `bk_cfg` one-hot with bit0 = 4 banks and bit1 = 8 banks.
  - 4 banks: b0 = x3^y[4+c] and b1 = x4^y[3+c], with x5 also XORed into b1 when `alt_swz` is 1.
  - 8 banks: b0 = x3^y[5+c], b1 = x4^y[4+c]^y[5+c] and b2 = x5^y[3+c], with x6 also XORed into b2 when `alt_swz` is 1.
- R3: The macro tile offset is (row × per_row + col) × macro_bytes, where:
  - E is the element size in bytes (1, 2 or 4);
  - row = y/8/channels and col = x/8/banks;
  - per_row = pitch/E/8/banks;
  - macro_bytes = banks × channels × 64 × E.
- R4: For colour surfaces the pixel number is built from bits pn[0..5] (the sequence lists pn[0] first). The element offset is pn × E. The bit sequence for each element size (`esz_in` 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) is:
  - 1 byte: x0, x1, x2, y1, y0, y2.
  - 2 bytes: x0, x1, x2, y0, y1, y2.
  - 4 bytes: x0, x1, y0, x2, y1, y2.
- R5: For depth surfaces pn[0..5] = x0, y0, x1, y1, x2, y2. A 2-byte depth element sits at pn × 2.
- R6: A 4-byte depth surface stores stencil and depth separately within each tile. Stencil (`stencil_in` = 1) is at pn × 1. Depth is at 64 + pn × 3, which is never below 64.
- R7: The output offset is formed from the macro tile offset and the element offset. Let g = log2(group bytes), taken from one-hot `grp_cfg` bit g, and let k = c + log2(banks).
  - First, t = (macro offset >> k) + element offset.
  - The output keeps t's low g bits.
  - The output places the channel at bit g and the bank at bit g + c.
  - The output moves the rest of t up by k.
- R8: `err_out` is 1 for an unsupported request. This covers any configuration field that is not one-hot, `esz_in` = 3, depth with 1-byte elements, and stencil outside a 4-byte depth surface.
- R9: `valid_out` follows an accepted `valid_in` after exactly three unstalled clock edges.
- R10: While `stall` is 1, all outputs hold their values and a `valid_in` presented then is not accepted.
- R11: After reset, `valid_out` and `err_out` are 0.
- R12: Over a 64x32 pixel region with pitch 64 elements, no two pixels get the same offset. This holds for every channel count, bank count and surface mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze all pipeline stages |
| valid_in | input | 1 | Request present |
| x_in | input | XW | Pixel column |
| y_in | input | YW | Pixel row |
| pitch_in | input | PW | Surface pitch in bytes |
| esz_in | input | 2 | Element size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| depth_in | input | 1 | Depth surface |
| stencil_in | input | 1 | Stencil plane of a 4-byte depth surface |
| grp_cfg | input | GW | One-hot group size, bit g means 2^g bytes |
| ch_cfg | input | 3 | One-hot channel count (2, 4, 8) |
| bk_cfg | input | 2 | One-hot bank count (4, 8) |
| alt_swz | input | 1 | Alternate bank swizzle enable |
| valid_out | output | 1 | Offset present |
| off_out | output | OW | Byte offset |
| err_out | output | 1 | Unsupported request |

## Verification
The bench targets the XOR terms that move with the channel count, for example y[4+c] against y[3+c]. A design that used a fixed bit there would collide pixels in the uniqueness sweep. It also targets the swapped y0/y1 positions in the 1-byte order, which would make pixels (0,1) and (0,2) trade offsets. It checks the 64-byte stencil area ahead of the depth bytes, where a missing bias would make depth overlap stencil. It exercises the alternate swizzle term, whose loss shows up only at x5 or x6. A stall held over a full output catches a pipeline that leaks the stalled-in request or lets the output drift.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    typedef enum logic [1:0] {
        ESZ_1B  = 2'd0,
        ESZ_2B  = 2'd1,
        ESZ_4B  = 2'd2,
        ESZ_BAD = 2'd3
    } esz_e;

    localparam int FLDW = 3;   // width of channel and bank fields
    localparam int EOFW = 8;   // width of the in-tile byte offset
endpackage

// File: rtl/tsa_swizzle.sv
module tsa_swizzle
    import tsa_pkg::*;
(
    input  logic [3:0]      xs,      // x[6:3]
    input  logic [5:0]      ys,      // y[8:3]
    input  logic [2:0]      ch_cfg,
    input  logic [1:0]      bk_cfg,
    input  logic            alt,
    output logic [FLDW-1:0] chan,
    output logic [FLDW-1:0] bank,
    output logic [1:0]      cb,
    output logic [1:0]      bb
);
    always_comb begin
        cb   = 2'd1;
        chan = '0;
        unique case (ch_cfg)
            3'b100: begin
                cb   = 2'd3;
                chan = {xs[0] ^ ys[2], xs[1] ^ xs[2] ^ ys[1], xs[2] ^ ys[0]};
            end
            3'b010: begin
                cb   = 2'd2;
                chan = {1'b0, xs[0] ^ ys[1], xs[1] ^ ys[0]};
            end
            default: begin
                cb   = 2'd1;
                chan = {2'b00, xs[0] ^ ys[0]};
            end
        endcase
    end

    always_comb begin
        bb   = 2'd2;
        bank = '0;
        unique case (bk_cfg)
            2'b10: begin
                bb      = 2'd3;
                bank[0] = xs[0] ^ ys[2 + cb];
                bank[1] = xs[1] ^ ys[1 + cb] ^ ys[2 + cb];
                bank[2] = xs[2] ^ ys[cb] ^ (alt & xs[3]);
            end
            default: begin
                bb      = 2'd2;
                bank[0] = xs[0] ^ ys[1 + cb];
                bank[1] = xs[1] ^ ys[cb] ^ (alt & xs[2]);
            end
        endcase
    end
endmodule

// File: rtl/tsa_elem_ofs.sv
module tsa_elem_ofs
    import tsa_pkg::*;
(
    input  logic [2:0]      xl,
    input  logic [2:0]      yl,
    input  esz_e            esz,
    input  logic            depth,
    input  logic            stencil,
    output logic [EOFW-1:0] eofs
);
    logic [5:0] pn;

    always_comb begin
        pn   = '0;
        eofs = '0;
        if (depth) begin
            pn = {yl[2], xl[2], yl[1], xl[1], yl[0], xl[0]};
            unique case (esz)
                ESZ_4B:  eofs = stencil ? {2'b00, pn} : 8'd64 + 8'(pn) * 8'd3;
                ESZ_2B:  eofs = {1'b0, pn, 1'b0};
                default: eofs = '0;
            endcase
        end else begin
            unique case (esz)
                ESZ_1B: begin
                    pn   = {yl[2], yl[0], yl[1], xl[2], xl[1], xl[0]};
                    eofs = {2'b00, pn};
                end
                ESZ_2B: begin
                    pn   = {yl[2], yl[1], yl[0], xl[2], xl[1], xl[0]};
                    eofs = {1'b0, pn, 1'b0};
                end
                ESZ_4B: begin
                    pn   = {yl[2], yl[1], xl[2], yl[0], xl[1], xl[0]};
                    eofs = {pn, 2'b00};
                end
                default: eofs = '0;
            endcase
        end
    end

    // R6
    always_comb begin
        if (depth && esz == ESZ_4B && !stencil) begin
            stencil_split_chk: assert (eofs >= 8'd64);
        end
    end
endmodule

// File: rtl/tsa_splice.sv
module tsa_splice
    import tsa_pkg::*;
#(
    parameter int OW  = 32,
    parameter int LGW = 4
) (
    input  logic [OW-1:0]   tot,
    input  logic [FLDW-1:0] chan,
    input  logic [FLDW-1:0] bank,
    input  logic [LGW-1:0]  gb,
    input  logic [1:0]      cb,
    input  logic [1:0]      bb,
    output logic [OW-1:0]   off
);
    logic [OW-1:0] gmask;
    logic [OW-1:0] lo;
    logic [OW-1:0] hi;
    logic [2:0]    k;
    logic [LGW:0]  bank_pos;

    always_comb begin
        k        = {1'b0, cb} + {1'b0, bb};
        bank_pos = (LGW + 1)'(gb) + (LGW + 1)'(cb);
        gmask    = (OW'(1) << gb) - OW'(1);
        lo       = tot & gmask;
        hi       = (tot & ~gmask) << k;
        off      = hi + lo + (OW'(chan) << gb) + (OW'(bank) << bank_pos);
    end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
    import tsa_pkg::*;
#(
    parameter int XW = 14,
    parameter int YW = 14,
    parameter int PW = 16,
    parameter int OW = 32,
    parameter int GW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          valid_in,
    input  logic [XW-1:0] x_in,
    input  logic [YW-1:0] y_in,
    input  logic [PW-1:0] pitch_in,
    input  logic [1:0]    esz_in,
    input  logic          depth_in,
    input  logic          stencil_in,
    input  logic [GW-1:0] grp_cfg,
    input  logic [2:0]    ch_cfg,
    input  logic [1:0]    bk_cfg,
    input  logic          alt_swz,
    output logic          valid_out,
    output logic [OW-1:0] off_out,
    output logic          err_out
);
    localparam int LGW = (GW > 1) ? $clog2(GW) : 1;
    localparam int MW  = YW + PW + 1;

    function automatic logic [LGW-1:0] oh_index(input logic [GW-1:0] v);
        logic [LGW-1:0] r;
        r = '0;
        for (int i = 0; i < GW; i++) begin
            if (v[i]) r = LGW'(i);
        end
        return r;
    endfunction

    // ---------------- stage 1: swizzle, tile indices ----------------
    esz_e            esz;
    logic [FLDW-1:0] c_chan, c_bank;
    logic [1:0]      c_cb, c_bb, c_elog;
    logic [EOFW-1:0] c_eofs;
    logic            c_bad;

    assign esz = esz_e'(esz_in);

    tsa_swizzle u_swz (
        .xs     (x_in[6:3]),
        .ys     (y_in[8:3]),
        .ch_cfg (ch_cfg),
        .bk_cfg (bk_cfg),
        .alt    (alt_swz),
        .chan   (c_chan),
        .bank   (c_bank),
        .cb     (c_cb),
        .bb     (c_bb)
    );

    tsa_elem_ofs u_eofs (
        .xl      (x_in[2:0]),
        .yl      (y_in[2:0]),
        .esz     (esz),
        .depth   (depth_in),
        .stencil (stencil_in),
        .eofs    (c_eofs)
    );

    always_comb begin
        unique case (esz)
            ESZ_2B:  c_elog = 2'd1;
            ESZ_4B:  c_elog = 2'd2;
            default: c_elog = 2'd0;
        endcase
        c_bad = !$onehot(grp_cfg) || !$onehot(ch_cfg) || !$onehot(bk_cfg)
              || (esz == ESZ_BAD)
              || (depth_in && esz == ESZ_1B)
              || (stencil_in && !(depth_in && esz == ESZ_4B));
    end

    logic            s1_v, s1_err;
    logic [FLDW-1:0] s1_chan, s1_bank;
    logic [1:0]      s1_cb, s1_bb, s1_elog;
    logic [LGW-1:0]  s1_gb;
    logic [EOFW-1:0] s1_eofs;
    logic [YW-1:0]   s1_row;
    logic [XW-1:0]   s1_col;
    logic [PW-1:0]   s1_tpr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_err  <= 1'b0;
            s1_chan <= '0;
            s1_bank <= '0;
            s1_cb   <= '0;
            s1_bb   <= '0;
            s1_elog <= '0;
            s1_gb   <= '0;
            s1_eofs <= '0;
            s1_row  <= '0;
            s1_col  <= '0;
            s1_tpr  <= '0;
        end else if (!stall) begin
            s1_v    <= valid_in;
            s1_err  <= valid_in && c_bad;
            s1_chan <= c_chan;
            s1_bank <= c_bank;
            s1_cb   <= c_cb;
            s1_bb   <= c_bb;
            s1_elog <= c_elog;
            s1_gb   <= oh_index(grp_cfg);
            s1_eofs <= c_eofs;
            s1_row  <= y_in >> (3'd3 + {1'b0, c_cb});
            s1_col  <= x_in >> (3'd3 + {1'b0, c_bb});
            s1_tpr  <= pitch_in >> (4'd3 + 4'(c_bb) + 4'(c_elog));
        end
    end

    // ---------------- stage 2: macro tile product ----------------
    logic [MW-1:0] c_prod;
    logic [OW-1:0] c_tot;
    logic [3:0]    c_tsh;

    always_comb begin
        c_prod = MW'(s1_row) * MW'(s1_tpr) + MW'(s1_col);
        c_tsh  = 4'd6 + 4'(s1_elog);
        c_tot  = (OW'(c_prod) << c_tsh) + OW'(s1_eofs);
    end

    logic            s2_v, s2_err;
    logic [FLDW-1:0] s2_chan, s2_bank;
    logic [1:0]      s2_cb, s2_bb;
    logic [LGW-1:0]  s2_gb;
    logic [OW-1:0]   s2_tot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_err  <= 1'b0;
            s2_chan <= '0;
            s2_bank <= '0;
            s2_cb   <= '0;
            s2_bb   <= '0;
            s2_gb   <= '0;
            s2_tot  <= '0;
        end else if (!stall) begin
            s2_v    <= s1_v;
            s2_err  <= s1_err;
            s2_chan <= s1_chan;
            s2_bank <= s1_bank;
            s2_cb   <= s1_cb;
            s2_bb   <= s1_bb;
            s2_gb   <= s1_gb;
            s2_tot  <= c_tot;
        end
    end

    // ---------------- stage 3: splice ----------------
    logic [OW-1:0] c_off;

    tsa_splice #(.OW(OW), .LGW(LGW)) u_splice (
        .tot  (s2_tot),
        .chan (s2_chan),
        .bank (s2_bank),
        .gb   (s2_gb),
        .cb   (s2_cb),
        .bb   (s2_bb),
        .off  (c_off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            err_out   <= 1'b0;
            off_out   <= '0;
        end else if (!stall) begin
            valid_out <= s2_v;
            err_out   <= s2_err;
            off_out   <= c_off;
        end
    end

    // ---------------- checks ----------------
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && valid_out) |=> (valid_out && $stable(off_out) && $stable(err_out)));

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(stall) && !$past(stall, 2) && !$past(stall, 3))
        |-> (valid_out == $past(valid_in, 3)));

    // R8
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !stall && esz_in == 2'b11) |=> (s1_v && s1_err));

    // R8
    bad_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !stall && $countones(ch_cfg) != 1) |=> s1_err);
endmodule

// File: tb/test_tiled_addr_gen.sv
module test_tiled_addr_gen;
    localparam int XW = 14, YW = 14, PW = 16, OW = 32, GW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          valid_in = 1'b0;
    logic [XW-1:0] x_in = '0;
    logic [YW-1:0] y_in = '0;
    logic [PW-1:0] pitch_in = '0;
    logic [1:0]    esz_in = '0;
    logic          depth_in = 1'b0;
    logic          stencil_in = 1'b0;
    logic [GW-1:0] grp_cfg = '0;
    logic [2:0]    ch_cfg = '0;
    logic [1:0]    bk_cfg = '0;
    logic          alt_swz = 1'b0;
    logic          valid_out;
    logic [OW-1:0] off_out;
    logic          err_out;

    always #4 clk = ~clk;   // 125 MHz

    tiled_addr_gen #(.XW(XW), .YW(YW), .PW(PW), .OW(OW), .GW(GW)) i_tiled_addr_gen (
        .clk(clk), .rst_n(rst_n), .stall(stall), .valid_in(valid_in),
        .x_in(x_in), .y_in(y_in), .pitch_in(pitch_in), .esz_in(esz_in),
        .depth_in(depth_in), .stencil_in(stencil_in), .grp_cfg(grp_cfg),
        .ch_cfg(ch_cfg), .bk_cfg(bk_cfg), .alt_swz(alt_swz),
        .valid_out(valid_out), .off_out(off_out), .err_out(err_out)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // ---- reference model built from the requirement text ----
    function automatic int lg(input int v);
        int r = 0;
        while (v > 1) begin v = v >> 1; r++; end
        return r;
    endfunction

    function automatic int bt(input int v, input int i);
        return (v >> i) & 1;
    endfunction

    function automatic int ref_off(input int x, input int y, input int pitch, input int eb,
                                   input int dep, input int stn, input int glog,
                                   input int nch, input int nbk, input int alt);
        int c, b, ch, bk, per_row, mbytes, mofs, pn, eo, t, lo, hi, gbytes;
        c = lg(nch); b = lg(nbk); gbytes = 1 << glog;
        if (nch == 8)      ch = (bt(x,5)^bt(y,3)) | ((bt(x,4)^bt(x,5)^bt(y,4)) << 1) | ((bt(x,3)^bt(y,5)) << 2);
        else if (nch == 4) ch = (bt(x,4)^bt(y,3)) | ((bt(x,3)^bt(y,4)) << 1);
        else               ch = bt(x,3)^bt(y,3);
        if (nbk == 8)
            bk = (bt(x,3)^bt(y,5+c)) | ((bt(x,4)^bt(y,4+c)^bt(y,5+c)) << 1)
               | ((bt(x,5)^bt(y,3+c)^(alt & bt(x,6))) << 2);
        else
            bk = (bt(x,3)^bt(y,4+c)) | ((bt(x,4)^bt(y,3+c)^(alt & bt(x,5))) << 1);
        per_row = (pitch / eb / 8) / nbk;
        mbytes  = nbk * nch * 64 * eb;
        mofs    = ((y / 8 / nch) * per_row + (x / 8 / nbk)) * mbytes;
        if (dep != 0) begin
            pn = bt(x,0) | bt(y,0)<<1 | bt(x,1)<<2 | bt(y,1)<<3 | bt(x,2)<<4 | bt(y,2)<<5;
            if (eb == 2)       eo = pn * 2;
            else if (stn != 0) eo = pn;
            else               eo = 64 + 3 * pn;
        end else begin
            if (eb == 1)      pn = bt(x,0) | bt(x,1)<<1 | bt(x,2)<<2 | bt(y,1)<<3 | bt(y,0)<<4 | bt(y,2)<<5;
            else if (eb == 2) pn = bt(x,0) | bt(x,1)<<1 | bt(x,2)<<2 | bt(y,0)<<3 | bt(y,1)<<4 | bt(y,2)<<5;
            else              pn = bt(x,0) | bt(x,1)<<1 | bt(y,0)<<2 | bt(x,2)<<3 | bt(y,1)<<4 | bt(y,2)<<5;
            eo = pn * eb;
        end
        t  = (mofs >> (c + b)) + eo;
        lo = t % gbytes;
        hi = (t - lo) << (c + b);
        return hi + lo + ch * gbytes + bk * (gbytes << c);
    endfunction

    // ---- expected-result queue and output monitor ----
    typedef struct { int off; bit err; int rq; } exp_t;
    exp_t expq[$];
    bit   seen[int];
    bit   track = 1'b0;
    int   coll = 0;

    always @(negedge clk) begin
        if (rst_n && valid_out && !stall && !done) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10 unexpected output", off_out, -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(err_out == e.err, $sformatf("R%0d err", e.rq), err_out, e.err);
                if (!e.err) chk(off_out == OW'(e.off), $sformatf("R%0d off", e.rq), off_out, e.off);
                if (track && !e.err) begin
                    if (seen.exists(int'(off_out))) coll++;
                    else seen[int'(off_out)] = 1'b1;
                end
            end
        end
    end

    task automatic drive(input int x, input int y, input int pitch, input int esz,
                         input int dep, input int stn, input int glog, input int nch,
                         input int nbk, input int alt, input int eoff, input bit eerr,
                         input int rq);
        exp_t e;
        @(posedge clk); #2;
        x_in = XW'(x); y_in = YW'(y); pitch_in = PW'(pitch); esz_in = 2'(esz);
        depth_in = dep[0]; stencil_in = stn[0]; grp_cfg = GW'(1) << glog;
        ch_cfg = (nch == 8) ? 3'b100 : (nch == 4) ? 3'b010 : (nch == 2) ? 3'b001 : 3'b011;
        bk_cfg = (nbk == 8) ? 2'b10 : 2'b01;
        alt_swz = alt[0];
        valid_in = 1'b1;
        e.off = eoff; e.err = eerr; e.rq = rq;
        expq.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #2;
        valid_in = 1'b0;
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    // ---- vector table: x,y,pitch,esz,dep,stn,glog,nch,nbk,alt,off,err,rq ----
    typedef struct packed {
        logic [31:0] x, y, pitch, esz, dep, stn, glog, nch, nbk, alt, off, err, rq;
    } vec_t;
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{0,  0, 256, 2, 0, 0, 8, 2, 4, 0,    0, 0, 7},  // R7 origin
        '{1,  0, 256, 2, 0, 0, 8, 2, 4, 0,    4, 0, 4},  // R4 4-byte x0
        '{8,  0, 256, 2, 0, 0, 8, 2, 4, 0,  768, 0, 1},  // R1 channel and bank from x3
        '{0,  1, 256, 2, 0, 0, 8, 2, 4, 0,   16, 0, 4},  // R4 4-byte y0 at pn bit 2
        '{32, 0, 256, 2, 0, 0, 8, 2, 4, 0, 2048, 0, 3},  // R3 next macro tile column
        '{32, 0, 256, 2, 0, 0, 8, 2, 4, 1, 3072, 0, 2},  // R2 alternate swizzle adds x5
        '{0,  1,  64, 0, 0, 0, 8, 2, 4, 0,   16, 0, 4},  // R4 1-byte y0 at pn bit 4
        '{0,  2,  64, 0, 0, 0, 8, 2, 4, 0,    8, 0, 4},  // R4 1-byte y1 at pn bit 3
        '{0,  1, 128, 1, 0, 0, 8, 2, 4, 0,   16, 0, 4},  // R4 2-byte y0 at pn bit 3
        '{0,  0, 256, 2, 1, 0, 8, 2, 4, 0,   64, 0, 6},  // R6 depth after stencil area
        '{1,  0, 256, 2, 1, 1, 8, 2, 4, 0,    1, 0, 6},  // R6 stencil one byte each
        '{0,  1, 256, 2, 1, 0, 8, 2, 4, 0,   70, 0, 5},  // R5 depth y0 at pn bit 1
        '{0,  1, 128, 1, 1, 0, 8, 2, 4, 0,    4, 0, 5},  // R5 2-byte depth
        '{8,  0, 256, 2, 0, 0, 8, 8, 8, 0, 3072, 0, 1},  // R1 eight channels, eight banks
        '{8,  0, 256, 2, 0, 0, 9, 2, 4, 0, 1536, 0, 7},  // R7 512-byte group
        '{0,  0,  64, 3, 0, 0, 8, 2, 4, 0,    0, 1, 8},  // R8 bad size code
        '{0,  0,  64, 0, 1, 0, 8, 2, 4, 0,    0, 1, 8},  // R8 1-byte depth
        '{0,  0,  64, 0, 0, 0, 8, 3, 4, 0,    0, 1, 8}   // R8 channel field not one-hot
    };

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(valid_out == 1'b0, "R11 valid_out in reset", valid_out, 0);
        chk(err_out == 1'b0, "R11 err_out in reset", err_out, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        chk(valid_out == 1'b0, "R11 valid_out after reset", valid_out, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].x, VECS[i].y, VECS[i].pitch, VECS[i].esz, VECS[i].dep, VECS[i].stn,
                  VECS[i].glog, VECS[i].nch, VECS[i].nbk, VECS[i].alt, VECS[i].off,
                  VECS[i].err[0], VECS[i].rq);
        end
        idle();
        drain();

        // R9 latency: one request into an empty pipe
        drive(8, 0, 256, 2, 0, 0, 8, 2, 4, 0, 768, 1'b0, 9);
        idle();
        @(negedge clk);
        @(negedge clk);
        chk(valid_out == 1'b0, "R9 early valid_out", valid_out, 0);
        @(negedge clk);
        chk(valid_out == 1'b1, "R9 valid_out at third edge", valid_out, 1);
        drain();

        // R10 stall holds the output and refuses new input
        drive(32, 0, 256, 2, 0, 0, 8, 2, 4, 0, 2048, 1'b0, 10);
        idle();
        @(posedge clk); #2;
        @(posedge clk); #2;
        stall = 1'b1;
        valid_in = 1'b1; x_in = 14'd8; y_in = 14'd0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(valid_out == 1'b1, "R10 valid held", valid_out, 1);
            chk(off_out == 32'd2048, "R10 offset held", off_out, 2048);
        end
        @(posedge clk); #2;
        stall = 1'b0; valid_in = 1'b0;
        drain();
        chk(expq.size() == 0, "R10 queue empty after stall", expq.size(), 0);

        // R12 sweep with reference model (also covers R1 R2 R3 R4 R5 R6 R7)
        for (int m = 0; m < 6; m++) begin
            for (int ci = 0; ci < 3; ci++) begin
                for (int bi = 0; bi < 2; bi++) begin
                    int esz, eb, dep, stn, nch, nbk, alt;
                    esz = (m == 0) ? 0 : (m == 1 || m == 3) ? 1 : 2;
                    eb  = 1 << esz;
                    dep = (m >= 3) ? 1 : 0;
                    stn = (m == 5) ? 1 : 0;
                    nch = 2 << ci;
                    nbk = 4 << bi;
                    alt = (m + ci) & 1;
                    seen.delete();
                    coll = 0;
                    track = 1'b1;
                    for (int y = 0; y < 32; y++) begin
                        for (int x = 0; x < 64; x++) begin
                            drive(x, y, 64 * eb, esz, dep, stn, 8, nch, nbk, alt,
                                  ref_off(x, y, 64 * eb, eb, dep, stn, 8, nch, nbk, alt),
                                  1'b0, 3);
                        end
                    end
                    idle();
                    drain();
                    track = 1'b0;
                    chk(coll == 0, $sformatf("R12 collisions mode %0d ch %0d bk %0d", m, nch, nbk), coll, 0);
                    chk(expq.size() == 0, "R9 outputs missing", expq.size(), 0);
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule